// File: doc/BRIEF.md
# Video-Mode Line and Frame Timer

This block paces a video-mode display link. A horizontal counter runs in byte-clock cycles and a vertical counter runs in lines. From these the block reports which part of the frame the link is in: vertical sync, vertical back porch, active lines or vertical front porch. Within each line it also reports the horizontal sync, back porch, active interval or front porch. It pulses strobes at the start of every line and every frame. It raises a flag whenever the lanes may drop to low power, with a separate enable for each blanking region. A packet formatter downstream uses these outputs to decide what to send in each byte-clock cycle.

Horizontal intervals are programmed directly in byte-clock cycles. The sync and back-porch widths share one packed word, and the line length and active width are separate values; the front porch is whatever remains of the line. The vertical porch and sync counts share a second packed word, and the number of active lines is separate. In the two modes without sync pulses, the horizontal sync width is folded into the back porch. A run control held low keeps the timer idle. The whole configuration is sampled at each frame start, so a change written mid-frame waits for the next frame.

Top module: `vid_line_frame_timer`

## Requirements
- R1: While `rst` is high, or from the second rising edge after `run` is sampled low, `vregion` is 0 (idle), `hregion` is 0, and `lp_ok`, `line_start`, `frame_start` and `frame_ack` are all 0.
- R2: Each frame visits its vertical regions in this order, each for the given number of lines: sync (code 1) for `vblank_word[29:20]` lines, back porch (code 2) for `vblank_word[19:10]` lines, active (code 3) for `vact_lines` lines, then front porch (code 4) for `vblank_word[9:0]` lines. A region with a count of zero is skipped. A frame whose four counts are all zero lasts one line, shown as front porch.
- R3: Each line lasts `line_time` byte-clock cycles, or 1 cycle when `line_time` is 0. `line_start` is high in the first cycle of every line. `frame_start` is high in the first cycle of the first line of each frame.
- R4: With `vmode` = 0 (non-burst, sync pulses), each line shows `hregion` = 0 (sync) for `hblank_word[31:16]` cycles, then 1 (back porch) for `hblank_word[15:0]` cycles, then 2 (active) for `pix_time` cycles, then 3 (front porch) for the rest of the line.
- R5: With `vmode` = 1 (non-burst, sync events), 2 (burst) or 3 (treated as burst), `hregion` is never 0. The back porch lasts the sum of the sync and back-porch widths, and the active and front-porch intervals follow as in R4.
- R6: On vertical sync, back-porch and front-porch lines, `lp_ok` equals `lp_mask[0]`, `lp_mask[1]` and `lp_mask[2]` respectively, for the whole line.
- R7: On active lines, `lp_ok` is high only when `lp_mask[3]` is set and either the line is in its back porch with `lp_mask[4]` set or in its front porch with `lp_mask[5]` set. `lp_ok` is never high in a horizontal sync or active interval.
- R8: `frame_ack` is high in the last cycle of a frame when `ack_req_en` was set at that frame's start, and is low at all other times.
- R9: Every configuration input is sampled together in the cycle a frame starts. A change made mid-frame has no effect on outputs until the next frame starts.
- R10: Outputs lag the timing position by one cycle. After `run` is first sampled high, `frame_start` appears one rising edge later, with `vregion` and `hregion` showing the first cycle of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 lets the timer run, 0 holds it idle |
| vmode | input | 2 | 0 sync pulses, 1 sync events, 2 or 3 burst |
| lp_mask | input | 6 | Low-power enables: [0] vsync, [1] vback, [2] vfront, [3] active lines, [4] hback, [5] hfront |
| ack_req_en | input | 1 | Request a frame-end acknowledge pulse |
| hblank_word | input | 2*HT_W | [31:16] sync width, [15:0] back-porch width, in cycles |
| line_time | input | HT_W | Line length in cycles |
| pix_time | input | HT_W | Active interval length in cycles |
| vblank_word | input | 3*VB_W | [29:20] sync, [19:10] back porch, [9:0] front porch, in lines |
| vact_lines | input | VA_W | Active lines per frame |
| vregion | output | 3 | 0 idle, 1 vsync, 2 vback, 3 active, 4 vfront |
| hregion | output | 2 | 0 sync, 1 back porch, 2 active, 3 front porch |
| lp_ok | output | 1 | Lanes may enter low power this cycle |
| line_start | output | 1 | First cycle of a line |
| frame_start | output | 1 | First cycle of a frame |
| frame_ack | output | 1 | Last cycle of a frame with acknowledge requested |

## Verification
Every output is registered one stage after the position counters, so each result is due exactly one rising edge after the counter state it describes. A run request shows as `frame_start` on the second edge that sees `run` high, and a stop shows as idle on the second edge after `run` drops. The bench model steps its own counters on each rising edge and computes that edge's expected outputs from its state before the update. It compares them at the following falling edge, which keeps the model aligned with the one-stage lag. Directed checks sample at exactly those offsets for start, stop and a configuration change made mid-frame.

// File: rtl/vlft_pkg.sv
package vlft_pkg;

  typedef enum logic [2:0] {
    V_IDLE  = 3'd0,
    V_SYNC  = 3'd1,
    V_BACK  = 3'd2,
    V_ACT   = 3'd3,
    V_FRONT = 3'd4
  } vreg_e;

  typedef enum logic [1:0] {
    H_SYNC  = 2'd0,
    H_BACK  = 2'd1,
    H_ACT   = 2'd2,
    H_FRONT = 2'd3
  } hreg_e;

  // vmode encoding
  localparam logic [1:0] MODE_PULSE = 2'd0;

  // lp_mask bit indices
  localparam int LPI_VSA  = 0;
  localparam int LPI_VBP  = 1;
  localparam int LPI_VFP  = 2;
  localparam int LPI_VACT = 3;
  localparam int LPI_HBP  = 4;
  localparam int LPI_HFP  = 5;
  localparam int LP_W     = 6;

endpackage

// File: rtl/vlft_shadow.sv
// Frame-start configuration capture; converts widths to region boundaries.
module vlft_shadow #(
  parameter int HT_W = 16,
  parameter int VB_W = 10,
  parameter int VA_W = 12,
  parameter int VS_W = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [1:0]            vmode,
  input  logic [vlft_pkg::LP_W-1:0] lp_mask,
  input  logic                  ack_req_en,
  input  logic [2*HT_W-1:0]     hblank_word,
  input  logic [HT_W-1:0]       line_time,
  input  logic [HT_W-1:0]       pix_time,
  input  logic [3*VB_W-1:0]     vblank_word,
  input  logic [VA_W-1:0]       vact_lines,
  output logic [HT_W+1:0]       b_sync,
  output logic [HT_W+1:0]       b_back,
  output logic [HT_W+1:0]       b_act,
  output logic [HT_W-1:0]       h_last,
  output logic [VS_W-1:0]       v_b1,
  output logic [VS_W-1:0]       v_b2,
  output logic [VS_W-1:0]       v_b3,
  output logic [VS_W-1:0]       v_last,
  output logic [vlft_pkg::LP_W-1:0] lp_q,
  output logic                  ack_q
);
  import vlft_pkg::*;

  localparam int HS_W = HT_W + 2;

  logic [HS_W-1:0] hsa_x, hbp_x, pix_x;
  logic [HS_W-1:0] n_sync, n_back, n_act;
  logic [HT_W-1:0] n_hlast;
  logic [VS_W-1:0] vsa_x, vbp_x, vfp_x, vact_x;
  logic [VS_W-1:0] n_v1, n_v2, n_v3, n_tot, n_vlast;

  always_comb begin
    hsa_x  = HS_W'(hblank_word[2*HT_W-1:HT_W]);
    hbp_x  = HS_W'(hblank_word[HT_W-1:0]);
    pix_x  = HS_W'(pix_time);
    n_sync = (vmode == MODE_PULSE) ? hsa_x : '0;
    n_back = hsa_x + hbp_x;
    n_act  = n_back + pix_x;
    n_hlast = (line_time == '0) ? '0 : line_time - HT_W'(1);

    vsa_x  = VS_W'(vblank_word[3*VB_W-1:2*VB_W]);
    vbp_x  = VS_W'(vblank_word[2*VB_W-1:VB_W]);
    vfp_x  = VS_W'(vblank_word[VB_W-1:0]);
    vact_x = VS_W'(vact_lines);
    n_v1   = vsa_x;
    n_v2   = n_v1 + vbp_x;
    n_v3   = n_v2 + vact_x;
    n_tot  = n_v3 + vfp_x;
    n_vlast = (n_tot == '0) ? '0 : n_tot - VS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_sync <= '0;
      b_back <= '0;
      b_act  <= '0;
      h_last <= '0;
      v_b1   <= '0;
      v_b2   <= '0;
      v_b3   <= '0;
      v_last <= '0;
      lp_q   <= '0;
      ack_q  <= 1'b0;
    end else if (load) begin
      b_sync <= n_sync;
      b_back <= n_back;
      b_act  <= n_act;
      h_last <= n_hlast;
      v_b1   <= n_v1;
      v_b2   <= n_v2;
      v_b3   <= n_v3;
      v_last <= n_vlast;
      lp_q   <= lp_mask;
      ack_q  <= ack_req_en;
    end
  end

endmodule

// File: rtl/vlft_counters.sv
// Byte-cycle and line position counters with run control.
module vlft_counters #(
  parameter int HT_W = 16,
  parameter int VS_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [HT_W-1:0] h_last,
  input  logic [VS_W-1:0] v_last,
  output logic            active,
  output logic [HT_W-1:0] h_pos,
  output logic [VS_W-1:0] v_pos,
  output logic            load
);

  logic line_end, frame_end;

  always_comb begin
    line_end  = (h_pos == h_last);
    frame_end = line_end && (v_pos == v_last);
    load      = run && (!active || frame_end);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      active <= 1'b0;
      h_pos  <= '0;
      v_pos  <= '0;
    end else if (!active) begin
      active <= 1'b1;
      h_pos  <= '0;
      v_pos  <= '0;
    end else if (line_end) begin
      h_pos <= '0;
      v_pos <= frame_end ? '0 : v_pos + VS_W'(1);
    end else begin
      h_pos <= h_pos + HT_W'(1);
    end
  end

endmodule

// File: rtl/vlft_region_decode.sv
// Registered region, strobe and low-power decode of the counter position.
module vlft_region_decode #(
  parameter int HT_W = 16,
  parameter int VS_W = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  active,
  input  logic [HT_W-1:0]       h_pos,
  input  logic [VS_W-1:0]       v_pos,
  input  logic [HT_W+1:0]       b_sync,
  input  logic [HT_W+1:0]       b_back,
  input  logic [HT_W+1:0]       b_act,
  input  logic [HT_W-1:0]       h_last,
  input  logic [VS_W-1:0]       v_b1,
  input  logic [VS_W-1:0]       v_b2,
  input  logic [VS_W-1:0]       v_b3,
  input  logic [VS_W-1:0]       v_last,
  input  logic [vlft_pkg::LP_W-1:0] lp_q,
  input  logic                  ack_q,
  output vlft_pkg::vreg_e       v_out,
  output vlft_pkg::hreg_e       h_out,
  output logic                  lp_out,
  output logic                  ls_out,
  output logic                  fs_out,
  output logic                  ack_out
);
  import vlft_pkg::*;

  localparam int HS_W = HT_W + 2;

  logic [HS_W-1:0] hx;
  hreg_e h_n;
  vreg_e v_n;
  logic  lp_n, ls_n, fs_n, ack_n;

  always_comb begin
    hx = {2'b00, h_pos};
    if (hx < b_sync)      h_n = H_SYNC;
    else if (hx < b_back) h_n = H_BACK;
    else if (hx < b_act)  h_n = H_ACT;
    else                  h_n = H_FRONT;

    if (v_pos < v_b1)      v_n = V_SYNC;
    else if (v_pos < v_b2) v_n = V_BACK;
    else if (v_pos < v_b3) v_n = V_ACT;
    else                   v_n = V_FRONT;

    case (v_n)
      V_SYNC:  lp_n = lp_q[LPI_VSA];
      V_BACK:  lp_n = lp_q[LPI_VBP];
      V_FRONT: lp_n = lp_q[LPI_VFP];
      V_ACT:   lp_n = lp_q[LPI_VACT] &&
                      (((h_n == H_BACK)  && lp_q[LPI_HBP]) ||
                       ((h_n == H_FRONT) && lp_q[LPI_HFP]));
      default: lp_n = 1'b0;
    endcase

    ls_n  = (h_pos == '0);
    fs_n  = ls_n && (v_pos == '0);
    ack_n = ack_q && (h_pos == h_last) && (v_pos == v_last);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      v_out   <= V_IDLE;
      h_out   <= H_SYNC;
      lp_out  <= 1'b0;
      ls_out  <= 1'b0;
      fs_out  <= 1'b0;
      ack_out <= 1'b0;
    end else begin
      v_out   <= v_n;
      h_out   <= h_n;
      lp_out  <= lp_n;
      ls_out  <= ls_n;
      fs_out  <= fs_n;
      ack_out <= ack_n;
    end
  end

endmodule

// File: rtl/vid_line_frame_timer.sv
// Video-mode line and frame timer top.
module vid_line_frame_timer #(
  parameter int HT_W = 16,
  parameter int VB_W = 10,
  parameter int VA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [1:0]        vmode,
  input  logic [5:0]        lp_mask,
  input  logic              ack_req_en,
  input  logic [2*HT_W-1:0] hblank_word,
  input  logic [HT_W-1:0]   line_time,
  input  logic [HT_W-1:0]   pix_time,
  input  logic [3*VB_W-1:0] vblank_word,
  input  logic [VA_W-1:0]   vact_lines,
  output logic [2:0]        vregion,
  output logic [1:0]        hregion,
  output logic              lp_ok,
  output logic              line_start,
  output logic              frame_start,
  output logic              frame_ack
);
  import vlft_pkg::*;

  localparam int VS_W = ((VB_W > VA_W) ? VB_W : VA_W) + 2;
  localparam int HS_W = HT_W + 2;

  logic            load, active;
  logic [HT_W-1:0] h_pos, h_last;
  logic [VS_W-1:0] v_pos, v_b1, v_b2, v_b3, v_last;
  logic [HS_W-1:0] b_sync, b_back, b_act;
  logic [LP_W-1:0] lp_q;
  logic            ack_q;
  vreg_e           v_out;
  hreg_e           h_out;

  vlft_shadow #(.HT_W(HT_W), .VB_W(VB_W), .VA_W(VA_W), .VS_W(VS_W)) u_shadow (
    .clk(clk), .rst(rst), .load(load),
    .vmode(vmode), .lp_mask(lp_mask), .ack_req_en(ack_req_en),
    .hblank_word(hblank_word), .line_time(line_time), .pix_time(pix_time),
    .vblank_word(vblank_word), .vact_lines(vact_lines),
    .b_sync(b_sync), .b_back(b_back), .b_act(b_act), .h_last(h_last),
    .v_b1(v_b1), .v_b2(v_b2), .v_b3(v_b3), .v_last(v_last),
    .lp_q(lp_q), .ack_q(ack_q)
  );

  vlft_counters #(.HT_W(HT_W), .VS_W(VS_W)) u_count (
    .clk(clk), .rst(rst), .run(run),
    .h_last(h_last), .v_last(v_last),
    .active(active), .h_pos(h_pos), .v_pos(v_pos), .load(load)
  );

  vlft_region_decode #(.HT_W(HT_W), .VS_W(VS_W)) u_decode (
    .clk(clk), .rst(rst), .active(active),
    .h_pos(h_pos), .v_pos(v_pos),
    .b_sync(b_sync), .b_back(b_back), .b_act(b_act), .h_last(h_last),
    .v_b1(v_b1), .v_b2(v_b2), .v_b3(v_b3), .v_last(v_last),
    .lp_q(lp_q), .ack_q(ack_q),
    .v_out(v_out), .h_out(h_out), .lp_out(lp_ok),
    .ls_out(line_start), .fs_out(frame_start), .ack_out(frame_ack)
  );

  assign vregion = v_out;
  assign hregion = h_out;

endmodule

// File: rtl/vlft_checker.sv
// Port-level properties of the timer, attached by bind.
module vlft_checker (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic [2:0] vregion,
  input logic [1:0] hregion,
  input logic       lp_ok,
  input logic       line_start,
  input logic       frame_start,
  input logic       frame_ack
);

  logic [1:0] since;

  always_ff @(posedge clk) begin
    if (rst)              since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  assert_idle_after_stop_R1: assert property (@(posedge clk) disable iff (rst)
    (since == 2'd3 && !$past(run, 2)) |-> (vregion == 3'd0 && !lp_ok && !line_start));

  assert_vregion_moves_on_line_R2: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0 && vregion != $past(vregion)) |-> (line_start || vregion == 3'd0));

  assert_frame_start_is_line_R3: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start);

  assert_hregion_forward_R4: assert property (@(posedge clk) disable iff (rst)
    (since != 2'd0 && vregion != 3'd0 && !line_start) |-> (hregion >= $past(hregion)));

  assert_no_lp_sync_or_pixels_R7: assert property (@(posedge clk) disable iff (rst)
    (vregion == 3'd3 && (hregion == 2'd0 || hregion == 2'd2)) |-> !lp_ok);

  assert_ack_before_frame_R8: assert property (@(posedge clk) disable iff (rst)
    frame_ack |=> (frame_start || vregion == 3'd0));

endmodule

bind vid_line_frame_timer vlft_checker u_vlft_chk (
  .clk(clk), .rst(rst), .run(run),
  .vregion(vregion), .hregion(hregion), .lp_ok(lp_ok),
  .line_start(line_start), .frame_start(frame_start), .frame_ack(frame_ack)
);

// File: tb/vid_line_frame_timer_test.sv
`timescale 1ns/1ps
module vid_line_frame_timer_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  always #2 clk = ~clk;

  int c_hsa = 2, c_hbp = 3, c_line = 14, c_pix = 5;
  int c_vsa = 1, c_vbp = 2, c_vfp = 2, c_vact = 3;
  int c_mode = 0, c_ack = 1;
  logic [5:0] c_lp = 6'b111111;

  logic [31:0] hblank_word;
  logic [29:0] vblank_word;
  logic [2:0]  vregion;
  logic [1:0]  hregion;
  logic        lp_ok, line_start, frame_start, frame_ack;

  assign hblank_word = {16'(c_hsa), 16'(c_hbp)};
  assign vblank_word = {10'(c_vsa), 10'(c_vbp), 10'(c_vfp)};

  vid_line_frame_timer uut (
    .clk(clk), .rst(rst), .run(run),
    .vmode(2'(c_mode)), .lp_mask(c_lp), .ack_req_en(c_ack != 0),
    .hblank_word(hblank_word), .line_time(16'(c_line)), .pix_time(16'(c_pix)),
    .vblank_word(vblank_word), .vact_lines(12'(c_vact)),
    .vregion(vregion), .hregion(hregion), .lp_ok(lp_ok),
    .line_start(line_start), .frame_start(frame_start), .frame_ack(frame_ack)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0, done = 0, mid = 0;

  // behavioural reference model state
  int m_act = 0, m_h = 0, m_v = 0;
  int s_sync, s_back, s_act, s_hlast, s_v1, s_v2, s_v3, s_vlast, s_ack, s_pulse;
  logic [5:0] s_lp;
  int e_v = 0, e_h = 0, e_lp = 0, e_ls = 0, e_fs = 0, e_ack = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic take_cfg();
    int tot;
    s_pulse = (c_mode == 0) ? 1 : 0;
    s_sync  = s_pulse ? c_hsa : 0;
    s_back  = c_hsa + c_hbp;
    s_act   = s_back + c_pix;
    s_hlast = (c_line == 0) ? 0 : c_line - 1;
    s_v1 = c_vsa; s_v2 = c_vsa + c_vbp; s_v3 = s_v2 + c_vact;
    tot = s_v3 + c_vfp;
    s_vlast = (tot == 0) ? 0 : tot - 1;
    s_lp = c_lp; s_ack = c_ack;
  endtask

  always @(posedge clk) begin
    started = 1;
    cyc++;
    if (rst) begin
      e_v = 0; e_h = 0; e_lp = 0; e_ls = 0; e_fs = 0; e_ack = 0;
      m_act = 0; m_h = 0; m_v = 0;
    end else begin
      if (!m_act) begin
        e_v = 0; e_h = 0; e_lp = 0; e_ls = 0; e_fs = 0; e_ack = 0;
      end else begin
        e_h = (m_h < s_sync) ? 0 : (m_h < s_back) ? 1 : (m_h < s_act) ? 2 : 3;
        e_v = (m_v < s_v1) ? 1 : (m_v < s_v2) ? 2 : (m_v < s_v3) ? 3 : 4;
        if (e_v == 1) e_lp = s_lp[0];
        else if (e_v == 2) e_lp = s_lp[1];
        else if (e_v == 4) e_lp = s_lp[2];
        else e_lp = (s_lp[3] && ((e_h == 1 && s_lp[4]) || (e_h == 3 && s_lp[5]))) ? 1 : 0;
        e_ls  = (m_h == 0) ? 1 : 0;
        e_fs  = (m_h == 0 && m_v == 0) ? 1 : 0;
        e_ack = (s_ack != 0 && m_h == s_hlast && m_v == s_vlast) ? 1 : 0;
      end
      if (!run) begin
        m_act = 0; m_h = 0; m_v = 0;
      end else if (!m_act) begin
        m_act = 1; m_h = 0; m_v = 0; take_cfg();
      end else if (m_h == s_hlast) begin
        m_h = 0;
        if (m_v == s_vlast) begin m_v = 0; take_cfg(); end
        else m_v++;
      end else m_h++;
    end
    if (cyc > 60000 && !done) begin
      fails++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 60000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      string p;
      p = mid ? "R9 " : "";
      chk({p, (e_v == 0) ? "R1 vregion" : "R2 vregion"}, int'(vregion), e_v);
      chk({p, (e_v == 0) ? "R1 hregion" : (s_pulse != 0 ? "R4 hregion" : "R5 hregion")},
          int'(hregion), e_h);
      chk({p, (e_v == 3) ? "R7 lp_ok" : "R6 lp_ok"}, int'(lp_ok), e_lp);
      chk({p, "R3 line_start"}, int'(line_start), e_ls);
      chk({p, "R3 frame_start"}, int'(frame_start), e_fs);
      chk({p, "R8 frame_ack"}, int'(frame_ack), e_ack);
    end
  end

  task automatic wait_frame();
    do @(negedge clk); while (!frame_start);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset vregion", int'(vregion), 0);
    chk("R1 reset lp_ok", int'(lp_ok), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle with run low", int'(line_start), 0);

    // sync-pulse mode, all low-power enables, acknowledge on
    run = 1'b1;
    @(negedge clk);
    chk("R10 no frame_start after first edge", int'(frame_start), 0);
    @(negedge clk);
    chk("R10 frame_start after second edge", int'(frame_start), 1);
    chk("R10 first region is vsync", int'(vregion), 1);
    chk("R10 first hregion is sync", int'(hregion), 0);
    repeat (230) @(negedge clk);

    // mid-frame change to sync-event mode
    wait_frame();
    repeat (20) @(negedge clk);
    mid = 1;
    c_mode = 1; c_lp = 6'b010101; c_ack = 0; c_hsa = 3; c_hbp = 2; c_line = 12; c_pix = 4;
    n = 0;
    do begin
      @(negedge clk);
      if (!frame_start && vregion != 3'd0 && hregion == 2'd0) n++;
    end while (!frame_start);
    mid = 0;
    chk("R9 old sync width kept until frame end", (n > 0) ? 1 : 0, 1);
    n = (hregion == 2'd0) ? 1 : 0;
    do begin
      @(negedge clk);
      if (!frame_start && hregion == 2'd0) n++;
    end while (!frame_start);
    chk("R5 no sync region in event mode", n, 0);

    // stop mid-frame
    repeat (30) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle two edges after stop", int'(vregion), 0);
    chk("R1 no lp while idle", int'(lp_ok), 0);

    // degenerate: one-cycle lines, active lines only, mode 3
    c_mode = 3; c_line = 0; c_hsa = 0; c_hbp = 0; c_pix = 0;
    c_vsa = 0; c_vbp = 0; c_vfp = 0; c_vact = 2; c_lp = 6'b101000; c_ack = 1;
    run = 1'b1;
    repeat (20) @(negedge clk);

    // degenerate: all vertical counts zero
    run = 1'b0;
    repeat (2) @(negedge clk);
    c_vact = 0; c_line = 5; c_lp = 6'b000100;
    run = 1'b1;
    repeat (20) @(negedge clk);

    // burst mode with active-line low power in front porch
    c_mode = 2; c_line = 16; c_hsa = 2; c_hbp = 2; c_pix = 6;
    c_vsa = 2; c_vbp = 1; c_vfp = 1; c_vact = 3; c_lp = 6'b101010; c_ack = 1;
    repeat (250) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule